// File: doc/BRIEF.md
# Transfer Byte Counter with Status

This block tracks the progress of a byte-oriented transfer on a bus data path. It holds a 24-bit remaining-length counter that steps down once for every byte the data path confirms as moved, and a 32-bit position counter that steps up on the same confirmations. Because both counters move only on confirmed completion, and never when a byte is merely issued, the position always points just past the last byte really delivered, even when the data path fetches ahead.

Software loads and reads both counters one byte at a time through a small register port. The block keeps four sticky status flags: count wrap, count done, PIO ready and DMA done. Each flag is cleared by writing a one to its bit at the status address. An enable register masks the flags onto a level interrupt. A separate strobe from the data path forces the remaining count to zero without raising the done flag.

Top module: `xfer_track`

## Requirements
- R1: After reset the count, the position, the status byte, the enable byte and `irq` are all zero.
- R2: The count is written and read as bytes at register offsets 0, 1 and 2, least significant byte at offset 0. A write replaces only the addressed byte.
- R3: Each cycle with `byte_done` high lowers the count by one. Without `byte_done` the count holds.
- R4: When a decrement takes the count from 1 to 0, status bit 2 (done, 0x04) is set. It stays set until it is cleared.
- R5: When a decrement is applied with the count at 0, the count becomes 0xFFFFFF and status bit 3 (wrap, 0x08) is set. It stays set until it is cleared.
- R6: The position is written and read as bytes at offsets 8 to 11, least significant byte at offset 8. It rises by one on each `byte_done` cycle that does not write one of its own bytes.
- R7: The status byte reads at offset 3, and its bits 7..4 read as zero. A write to offset 3 clears each status bit whose data bit is 1. Bits written as 0 keep their value.
- R8: A `pio_rdy` pulse sets status bit 1 (0x02). A `dma_done` pulse sets status bit 0 (0x01).
- R9: The enable byte is written and read at offset 4, bits 3..0, with the same bit positions as the status byte. `irq` is high exactly while some status bit and its enable bit are both 1.
- R10: `clr_cnt` sets the count to 0 on the next edge. It takes priority over count byte writes and over `byte_done`, and it never sets the done or wrap bit.
- R11: If a status bit is set and cleared by a write in the same cycle, the bit ends up set.
- R12: A write to a count byte in the same cycle as `byte_done` takes priority. The count takes the written byte with no decrement, and neither done nor wrap is set by that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 4 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational. Unmapped offsets read zero |
| byte_done | input | 1 | One byte confirmed transferred in this cycle |
| clr_cnt | input | 1 | Force the count to zero |
| pio_rdy | input | 1 | Set the PIO-ready status bit |
| dma_done | input | 1 | Set the DMA-done status bit |
| irq | output | 1 | Level interrupt: enabled status present |

## Verification
The properties assume that `byte_done`, `clr_cnt`, `pio_rdy` and `dma_done` are single-cycle synchronous strobes, and that register writes present a stable offset and data for the one cycle in which `reg_we` is high. The step properties also assume that a cycle is quiet except for the events they name. The directed stimulus drives every input on the falling edge and holds it for exactly one rising edge. Overlapping events are created only on purpose: clear with decrement, set with clear, and byte write with decrement. These let the priority rules be observed through reads at the ports.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
   // status bit positions, shared by the status and enable bytes
   localparam int ST_DMA  = 0;
   localparam int ST_PIO  = 1;
   localparam int ST_DONE = 2;
   localparam int ST_WRAP = 3;
   localparam int ST_N    = 4;
   localparam int BYTE_W  = 8;
endpackage

// File: rtl/xfer_downcnt.sv
module xfer_downcnt #(
   parameter int W = 24,
   localparam int NB = W / 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          zero_i,
   input  logic [NB-1:0] lane_we_i,
   input  logic [7:0]    wdata_i,
   input  logic          step_i,
   output logic [W-1:0]  q_o,
   output logic          reach_zero_o,
   output logic          wrap_o
);
   logic [W-1:0] q, loaded;
   logic         any_we, step_ok;

   assign any_we  = |lane_we_i;
   assign step_ok = step_i && !zero_i && !any_we;

   for (genvar i = 0; i < NB; i++) begin : g_lane
      assign loaded[8*i +: 8] = lane_we_i[i] ? wdata_i : q[8*i +: 8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (zero_i)   q <= '0;
      else if (any_we)   q <= loaded;
      else if (step_ok)  q <= q - W'(1);
   end

   assign reach_zero_o = step_ok && (q == W'(1));
   assign wrap_o       = step_ok && (q == '0);
   assign q_o          = q;
endmodule

// File: rtl/xfer_upcnt.sv
module xfer_upcnt #(
   parameter int W = 32,
   localparam int NB = W / 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] lane_we_i,
   input  logic [7:0]    wdata_i,
   input  logic          step_i,
   output logic [W-1:0]  q_o
);
   logic [W-1:0] q, loaded;

   for (genvar i = 0; i < NB; i++) begin : g_lane
      assign loaded[8*i +: 8] = lane_we_i[i] ? wdata_i : q[8*i +: 8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              q <= '0;
      else if (|lane_we_i)     q <= loaded;
      else if (step_i)         q <= q + W'(1);
   end

   assign q_o = q;
endmodule

// File: rtl/xfer_status.sv
module xfer_status #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   input  logic         en_we_i,
   input  logic [N-1:0] en_d_i,
   output logic [N-1:0] st_o,
   output logic [N-1:0] en_o,
   output logic         irq_o
);
   logic [N-1:0] st, en;

   for (genvar b = 0; b < N; b++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        st[b] <= 1'b0;
         else if (set_i[b]) st[b] <= 1'b1;
         else if (clr_i[b]) st[b] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en <= '0;
      else if (en_we_i) en <= en_d_i;
   end

   assign irq_o = |(st & en);
   assign st_o  = st;
   assign en_o  = en;
endmodule

// File: rtl/xfer_rdmux.sv
module xfer_rdmux #(
   parameter int RA_W = 4,
   parameter int CNT_W = 24,
   parameter int ADR_W = 32,
   parameter int ADR_BASE = 8,
   parameter int N = 4,
   localparam int CNT_BYTES = CNT_W / 8,
   localparam int ADR_BYTES = ADR_W / 8,
   localparam int OFS_STAT = CNT_BYTES,
   localparam int OFS_EN = CNT_BYTES + 1
) (
   input  logic [RA_W-1:0]  addr_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [ADR_W-1:0] adr_i,
   input  logic [N-1:0]     st_i,
   input  logic [N-1:0]     en_i,
   output logic [7:0]       rdata_o
);
   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < CNT_BYTES; i++)
         if (addr_i == RA_W'(i)) rdata_o = cnt_i[8*i +: 8];
      for (int j = 0; j < ADR_BYTES; j++)
         if (addr_i == RA_W'(ADR_BASE + j)) rdata_o = adr_i[8*j +: 8];
      if (addr_i == RA_W'(OFS_STAT)) rdata_o = 8'(st_i);
      if (addr_i == RA_W'(OFS_EN))   rdata_o = 8'(en_i);
   end
endmodule

// File: rtl/xfer_track.sv
module xfer_track
   import xfer_pkg::*;
#(
   parameter int RA_W = 4,
   parameter int CNT_W = 24,
   parameter int ADR_W = 32,
   parameter int ADR_BASE = 8,
   localparam int CNT_BYTES = CNT_W / 8,
   localparam int ADR_BYTES = ADR_W / 8,
   localparam int OFS_STAT = CNT_BYTES,
   localparam int OFS_EN = CNT_BYTES + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [RA_W-1:0] reg_addr,
   input  logic            reg_we,
   input  logic [7:0]      reg_wdata,
   output logic [7:0]      reg_rdata,
   input  logic            byte_done,
   input  logic            clr_cnt,
   input  logic            pio_rdy,
   input  logic            dma_done,
   output logic            irq
);
   if ((CNT_W % BYTE_W) != 0 || (ADR_W % BYTE_W) != 0) begin : g_bad_width
      $error("xfer_track: counter widths must be whole bytes");
   end
   if (ADR_BASE < OFS_EN + 1 || ADR_BASE + ADR_BYTES > (1 << RA_W)) begin : g_bad_map
      $error("xfer_track: register map does not fit the offset space");
   end

   logic [CNT_BYTES-1:0] cnt_lane;
   logic [ADR_BYTES-1:0] adr_lane;
   logic [CNT_W-1:0]     cnt_q;
   logic [ADR_W-1:0]     adr_q;
   logic [ST_N-1:0]      st_q, en_q, st_set, st_clr;
   logic                 hit_zero, hit_wrap, stat_we, en_we;

   for (genvar i = 0; i < CNT_BYTES; i++) begin : g_cnt_dec
      assign cnt_lane[i] = reg_we && (reg_addr == RA_W'(i));
   end
   for (genvar j = 0; j < ADR_BYTES; j++) begin : g_adr_dec
      assign adr_lane[j] = reg_we && (reg_addr == RA_W'(ADR_BASE + j));
   end

   assign stat_we = reg_we && (reg_addr == RA_W'(OFS_STAT));
   assign en_we   = reg_we && (reg_addr == RA_W'(OFS_EN));

   xfer_downcnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .zero_i(clr_cnt), .lane_we_i(cnt_lane),
      .wdata_i(reg_wdata), .step_i(byte_done), .q_o(cnt_q),
      .reach_zero_o(hit_zero), .wrap_o(hit_wrap)
   );

   xfer_upcnt #(.W(ADR_W)) u_adr (
      .clk(clk), .rst_n(rst_n), .lane_we_i(adr_lane), .wdata_i(reg_wdata),
      .step_i(byte_done), .q_o(adr_q)
   );

   always_comb begin
      st_set          = '0;
      st_set[ST_DMA]  = dma_done;
      st_set[ST_PIO]  = pio_rdy;
      st_set[ST_DONE] = hit_zero;
      st_set[ST_WRAP] = hit_wrap;
      st_clr          = stat_we ? reg_wdata[ST_N-1:0] : '0;
   end

   xfer_status #(.N(ST_N)) u_st (
      .clk(clk), .rst_n(rst_n), .set_i(st_set), .clr_i(st_clr),
      .en_we_i(en_we), .en_d_i(reg_wdata[ST_N-1:0]), .st_o(st_q),
      .en_o(en_q), .irq_o(irq)
   );

   xfer_rdmux #(
      .RA_W(RA_W), .CNT_W(CNT_W), .ADR_W(ADR_W), .ADR_BASE(ADR_BASE), .N(ST_N)
   ) u_rd (
      .addr_i(reg_addr), .cnt_i(cnt_q), .adr_i(adr_q), .st_i(st_q),
      .en_i(en_q), .rdata_o(reg_rdata)
   );
endmodule

// File: rtl/xfer_track_chk.sv
module xfer_track_chk
   import xfer_pkg::*;
#(
   parameter int RA_W = 4,
   parameter int CNT_W = 24,
   parameter int ADR_W = 32,
   parameter int ADR_BASE = 8,
   localparam int CNT_BYTES = CNT_W / 8,
   localparam int ADR_BYTES = ADR_W / 8,
   localparam int OFS_STAT = CNT_BYTES
) (
   input logic            clk,
   input logic            rst_n,
   input logic [RA_W-1:0] reg_addr,
   input logic            reg_we,
   input logic [7:0]      reg_wdata,
   input logic            byte_done,
   input logic            clr_cnt,
   input logic            pio_rdy,
   input logic            dma_done,
   input logic            irq,
   input logic [CNT_W-1:0] cnt_q,
   input logic [ADR_W-1:0] adr_q,
   input logic [ST_N-1:0]  st_q,
   input logic [ST_N-1:0]  en_q
);
   logic cnt_wr, adr_wr, step;
   assign cnt_wr = reg_we && (reg_addr < RA_W'(CNT_BYTES));
   assign adr_wr = reg_we && (reg_addr >= RA_W'(ADR_BASE))
                   && (reg_addr < RA_W'(ADR_BASE + ADR_BYTES));
   assign step   = byte_done && !clr_cnt && !cnt_wr;

   // R3
   dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> cnt_q == $past(cnt_q) - CNT_W'(1));
   // R4
   done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt_q == CNT_W'(1)) |=> st_q[ST_DONE] && cnt_q == '0);
   // R5
   wrap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt_q == '0) |=> st_q[ST_WRAP] && (&cnt_q));
   // R10
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_cnt |=> cnt_q == '0);
   // R10
   clr_nodone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_cnt && !st_q[ST_DONE]) |=> !st_q[ST_DONE]);
   // R6
   adr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && !adr_wr) |=> adr_q == $past(adr_q) + ADR_W'(1));
   // R7
   zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == RA_W'(OFS_STAT) && reg_wdata[ST_N-1:0] == '0
       && !pio_rdy && !dma_done && !byte_done) |=> $stable(st_q));
   // R11
   pio_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pio_rdy |=> st_q[ST_PIO]);
   // R9
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == '0 || en_q == '0) |-> !irq);
endmodule

bind xfer_track xfer_track_chk #(
   .RA_W(RA_W), .CNT_W(CNT_W), .ADR_W(ADR_W), .ADR_BASE(ADR_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
   .reg_wdata(reg_wdata), .byte_done(byte_done), .clr_cnt(clr_cnt),
   .pio_rdy(pio_rdy), .dma_done(dma_done), .irq(irq), .cnt_q(cnt_q),
   .adr_q(adr_q), .st_q(st_q), .en_q(en_q)
);

// File: tb/xfer_track_bench.sv
module xfer_track_bench;
   logic       clk = 1'b0, rst_n = 1'b0;
   logic [3:0] reg_addr = '0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       byte_done = 1'b0, clr_cnt = 1'b0, pio_rdy = 1'b0, dma_done = 1'b0;
   logic       irq;
   int         n_run = 0, n_fail = 0;
   bit         ended = 1'b0;

   always #5 clk = ~clk;

   xfer_track u_xfer_track (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .byte_done(byte_done),
      .clr_cnt(clr_cnt), .pio_rdy(pio_rdy), .dma_done(dma_done), .irq(irq)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic rd_cnt(output logic [31:0] v);
      logic [7:0] b0, b1, b2;
      rd(4'd0, b0); rd(4'd1, b1); rd(4'd2, b2);
      v = {8'h00, b2, b1, b0};
   endtask

   task automatic rd_adr(output logic [31:0] v);
      logic [7:0] b0, b1, b2, b3;
      rd(4'd8, b0); rd(4'd9, b1); rd(4'd10, b2); rd(4'd11, b3);
      v = {b3, b2, b1, b0};
   endtask

   task automatic rd_st(output logic [31:0] v);
      logic [7:0] b;
      rd(4'd3, b);
      v = {24'h0, b};
   endtask

   task automatic set_cnt(input logic [23:0] v);
      wr(4'd0, v[7:0]); wr(4'd1, v[15:8]); wr(4'd2, v[23:16]);
   endtask

   task automatic pulses(input int n);
      @(negedge clk);
      byte_done = 1'b1;
      repeat (n) @(negedge clk);
      byte_done = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      logic [7:0]  b;
      rd_cnt(v); check("R1 count", v, 0);
      rd_adr(v); check("R1 position", v, 0);
      rd_st(v);  check("R1 status", v, 0);
      rd(4'd4, b); check("R1 enable", {24'h0, b}, 0);
      check("R1 irq", {31'h0, irq}, 0);
   endtask

   task automatic t_load;
      logic [31:0] v;
      set_cnt(24'h563412);
      rd_cnt(v); check("R2 count load", v, 32'h563412);
      wr(4'd1, 8'hAB);
      rd_cnt(v); check("R2 single byte", v, 32'h56AB12);
      wr(4'd8, 8'hEF); wr(4'd9, 8'hBE); wr(4'd10, 8'hAD); wr(4'd11, 8'hDE);
      rd_adr(v); check("R6 position load", v, 32'hDEADBEEF);
   endtask

   task automatic t_dec;
      logic [31:0] v;
      set_cnt(24'd5);
      pulses(3);
      rd_cnt(v); check("R3 count after 3", v, 2);
      rd_adr(v); check("R6 position after 3", v, 32'hDEADBEF2);
      repeat (4) @(negedge clk);
      rd_cnt(v); check("R3 count holds", v, 2);
   endtask

   task automatic t_done_wrap;
      logic [31:0] v;
      wr(4'd3, 8'hFF);
      set_cnt(24'd2);
      pulses(2);
      rd_cnt(v); check("R4 count zero", v, 0);
      rd_st(v);  check("R4 done bit", v, 32'h04);
      pulses(1);
      rd_cnt(v); check("R5 wrapped count", v, 32'hFFFFFF);
      rd_st(v);  check("R5 wrap bit", v, 32'h0C);
      pulses(2);
      rd_cnt(v); check("R3 count below wrap", v, 32'hFFFFFD);
      rd_st(v);  check("R4 sticky", v, 32'h0C);
   endtask

   task automatic t_w1c;
      logic [31:0] v;
      wr(4'd3, 8'h08);
      rd_st(v); check("R7 clear wrap only", v, 32'h04);
      wr(4'd3, 8'h00);
      rd_st(v); check("R7 zero write keeps", v, 32'h04);
      wr(4'd3, 8'hF4);
      rd_st(v); check("R7 clear done", v, 32'h00);
   endtask

   task automatic t_events;
      logic [31:0] v;
      @(negedge clk); pio_rdy = 1'b1; @(negedge clk); pio_rdy = 1'b0;
      rd_st(v); check("R8 pio bit", v, 32'h02);
      @(negedge clk); dma_done = 1'b1; @(negedge clk); dma_done = 1'b0;
      rd_st(v); check("R8 dma bit", v, 32'h03);
   endtask

   task automatic t_irq;
      logic [7:0] b;
      check("R9 irq masked", {31'h0, irq}, 0);
      wr(4'd4, 8'h01);
      check("R9 irq dma enabled", {31'h0, irq}, 1);
      wr(4'd3, 8'h01);
      check("R9 irq after clear", {31'h0, irq}, 0);
      wr(4'd4, 8'h02);
      check("R9 irq pio enabled", {31'h0, irq}, 1);
      rd(4'd4, b); check("R9 enable readback", {24'h0, b}, 32'h02);
      wr(4'd4, 8'h00);
      wr(4'd3, 8'h0F);
      check("R9 irq off", {31'h0, irq}, 0);
   endtask

   task automatic t_clr;
      logic [31:0] v;
      set_cnt(24'd1);
      @(negedge clk); clr_cnt = 1'b1; byte_done = 1'b1;
      @(negedge clk); clr_cnt = 1'b0; byte_done = 1'b0;
      rd_cnt(v); check("R10 clear beats step", v, 0);
      rd_st(v);  check("R10 no done no wrap", v, 0);
      set_cnt(24'h000777);
      @(negedge clk); clr_cnt = 1'b1; reg_addr = 4'd0; reg_wdata = 8'h55; reg_we = 1'b1;
      @(negedge clk); clr_cnt = 1'b0; reg_we = 1'b0;
      rd_cnt(v); check("R10 clear beats write", v, 0);
   endtask

   task automatic t_set_wins;
      logic [31:0] v;
      @(negedge clk); pio_rdy = 1'b1; reg_addr = 4'd3; reg_wdata = 8'h02; reg_we = 1'b1;
      @(negedge clk); pio_rdy = 1'b0; reg_we = 1'b0;
      rd_st(v); check("R11 pio set wins", v, 32'h02);
      wr(4'd3, 8'h0F);
      set_cnt(24'd1);
      @(negedge clk); byte_done = 1'b1; reg_addr = 4'd3; reg_wdata = 8'h04; reg_we = 1'b1;
      @(negedge clk); byte_done = 1'b0; reg_we = 1'b0;
      rd_st(v); check("R11 done set wins", v, 32'h04);
      wr(4'd3, 8'h0F);
   endtask

   task automatic t_wr_prio;
      logic [31:0] v, p0;
      set_cnt(24'h000010);
      rd_adr(p0);
      @(negedge clk); byte_done = 1'b1; reg_addr = 4'd0; reg_wdata = 8'h80; reg_we = 1'b1;
      @(negedge clk); byte_done = 1'b0; reg_we = 1'b0;
      rd_cnt(v); check("R12 write beats step", v, 32'h000080);
      rd_adr(v); check("R6 position still steps", v, p0 + 1);
      set_cnt(24'd1);
      @(negedge clk); byte_done = 1'b1; reg_addr = 4'd1; reg_wdata = 8'h00; reg_we = 1'b1;
      @(negedge clk); byte_done = 1'b0; reg_we = 1'b0;
      rd_cnt(v); check("R12 no decrement", v, 1);
      rd_st(v);  check("R12 no done", v, 0);
   endtask

   initial begin
      #2_000_000;
      if (!ended) begin
         ended = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load();
      t_dec();
      t_done_wrap();
      t_w1c();
      t_events();
      t_irq();
      t_clr();
      t_set_wins();
      t_wr_prio();
      if (!ended) begin
         ended = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule